// File: doc/BRIEF.md
# Scrambled memory key and fill sequencer

This block sequences the two slow maintenance operations of a scrambled on-chip memory: fetching a fresh scrambling key and overwriting the whole array with pseudo-random data. Software sets a key renewal bit or an init bit, and each arrives here as a one-cycle write pulse. A key renewal runs a request/acknowledge handshake with an external key provider. The provider answers with a key and a nonce, possibly hundreds of cycles later. A fill seeds a 32-bit LFSR from the most recent nonce and writes one LFSR word per cycle to every address of the memory, from the lowest address to the highest.

The two operations are arbitrated against each other. A key renewal is dropped while either operation is pending. An init request is dropped while a fill is pending. When both bits are set by the same write, the key fetch runs first and the fill follows with the new nonce. The block reports key-valid and init-done, shows that a fill is outstanding, and produces a gate that holds off normal memory traffic until the memory is usable.

Top module: `sram_key_init_seq`

## Requirements
- R1: A renewal pulse is accepted only when no key request is outstanding and no fill is pending (init_busy_o low). Otherwise it is ignored: no new request is issued, and key_valid_o and key_req_o keep their values.
- R2: An init pulse while a fill is pending is ignored. The fill is not restarted, and each address is written exactly once per accepted init.
- R3: An accepted fill writes addresses 0, 1, … DEPTH-1, one per cycle, with no gaps. init_busy_o drops in the cycle after the write to DEPTH-1.
- R4: The first fill word is the seed: nonce_i[31:0] captured at the most recent accepted acknowledge. Each further word is one Galois step of the previous word: shift right by one, then XOR 32'h80200003 if the bit shifted out was 1.
- R5: When renewal and init pulse together, the key request is issued first. No memory write occurs while key_req_o is high, and the fill then uses the nonce from that request.
- R6: An accepted renewal raises key_req_o and clears key_valid_o on the next clock edge.
- R7: bus_gate_o is 1 (traffic blocked) whenever key_valid_o is 0 or a fill is pending.
- R8: key_req_o stays high until key_ack_i is seen. On that acknowledge, key_i is captured into key_o, key_valid_o rises and key_req_o drops, all on the next edge.
- R9: init_done_o clears on an accepted init and stays low during the fill. It rises only on the edge after the final address write.
- R10: A zero seed is replaced by the constant 32'h9E3779B9.
- R11: After reset, key_req_o, key_valid_o, init_busy_o, init_done_o and mem_we_o are 0 and bus_gate_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| renew_wr_i | input | 1 | One-cycle pulse: write of 1 to key renewal bit |
| init_wr_i | input | 1 | One-cycle pulse: write of 1 to init bit |
| key_req_o | output | 1 | Key request to the provider, held until acknowledge |
| key_ack_i | input | 1 | Provider acknowledge, one cycle |
| key_i | input | KEY_W | Key returned with the acknowledge |
| nonce_i | input | NONCE_W | Nonce returned with the acknowledge |
| key_o | output | KEY_W | Currently installed key |
| key_valid_o | output | 1 | Key installed and valid |
| init_busy_o | output | 1 | Fill requested and not yet finished |
| init_done_o | output | 1 | Last fill completed over the whole array |
| bus_gate_o | output | 1 | 1 blocks normal memory traffic |
| mem_we_o | output | 1 | Memory write enable during fill |
| mem_addr_o | output | $clog2(DEPTH) | Memory write address |
| mem_wdata_o | output | 32 | Memory write data from the LFSR |

## Verification
The assertions assume that each of key_ack_i, renew_wr_i and init_wr_i is high for at most one cycle at a time. They also assume that key_ack_i comes only while key_req_o is high, so that the handshake properties describe a well-behaved provider. The bench meets these assumptions by driving every write pulse for exactly one cycle, at the falling edge. Its provider model counts a programmable delay from a new request and raises the acknowledge for a single cycle, only while the request is still up.

// File: rtl/sram_key_init_seq.sv
module sram_key_init_seq #(
  parameter int DEPTH   = 256,
  parameter int KEY_W   = 128,
  parameter int NONCE_W = 64,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               renew_wr_i,
  input  logic               init_wr_i,
  output logic               key_req_o,
  input  logic               key_ack_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [NONCE_W-1:0] nonce_i,
  output logic [KEY_W-1:0]   key_o,
  output logic               key_valid_o,
  output logic               init_busy_o,
  output logic               init_done_o,
  output logic               bus_gate_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [31:0]        mem_wdata_o
);

  localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);
  localparam logic [31:0]   TAPS   = 32'h8020_0003;
  localparam logic [31:0]   NZSEED = 32'h9E37_79B9;

  logic             key_pend_q, key_valid_q;
  logic [KEY_W-1:0] key_q;
  logic [31:0]      seed_q, lfsr_q;
  logic             init_pend_q, run_q, done_q;
  logic [AW-1:0]    addr_q;

  logic key_go, ack_ok, init_go, start, last;
  logic [31:0] seed_eff, lfsr_nxt;

  assign ack_ok   = key_ack_i & key_pend_q;
  assign key_go   = renew_wr_i & ~key_pend_q & ~init_pend_q;
  assign init_go  = init_wr_i & ~init_pend_q;
  assign start    = init_pend_q & ~run_q & ~key_pend_q;
  assign last     = run_q & (addr_q == LAST);
  assign seed_eff = (seed_q == 32'h0) ? NZSEED : seed_q;
  assign lfsr_nxt = (lfsr_q >> 1) ^ (lfsr_q[0] ? TAPS : 32'h0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_pend_q  <= 1'b0;
      key_valid_q <= 1'b0;
      key_q       <= '0;
      seed_q      <= '0;
    end else if (key_go) begin
      key_pend_q  <= 1'b1;
      key_valid_q <= 1'b0;
    end else if (ack_ok) begin
      key_pend_q  <= 1'b0;
      key_valid_q <= 1'b1;
      key_q       <= key_i;
      seed_q      <= nonce_i[31:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_pend_q <= 1'b0;
      run_q       <= 1'b0;
      done_q      <= 1'b0;
      addr_q      <= '0;
      lfsr_q      <= '0;
    end else begin
      if (init_go) begin
        init_pend_q <= 1'b1;
        done_q      <= 1'b0;
      end
      if (start) begin
        run_q  <= 1'b1;
        addr_q <= '0;
        lfsr_q <= seed_eff;
      end else if (run_q) begin
        lfsr_q <= lfsr_nxt;
        addr_q <= addr_q + AW'(1);
        if (last) begin
          run_q       <= 1'b0;
          init_pend_q <= 1'b0;
          done_q      <= 1'b1;
        end
      end
    end
  end

  assign key_req_o   = key_pend_q;
  assign key_o       = key_q;
  assign key_valid_o = key_valid_q;
  assign init_busy_o = init_pend_q;
  assign init_done_o = done_q;
  assign bus_gate_o  = ~key_valid_q | init_pend_q;
  assign mem_we_o    = run_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = lfsr_q;

endmodule

// File: rtl/sram_key_init_seq_chk.sv
module sram_key_init_seq_chk #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          renew_wr_i,
  input logic          key_req_o,
  input logic          key_ack_i,
  input logic          key_valid_o,
  input logic          init_busy_o,
  input logic          init_done_o,
  input logic          bus_gate_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  p_renew_ignored_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (renew_wr_i && init_busy_o && key_valid_o && !key_req_o) |=> (key_valid_o && !key_req_o));

  p_fill_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o != LAST) |=> (mem_we_o && mem_addr_o == $past(mem_addr_o) + AW'(1)));

  p_fill_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o == LAST) |=> (!mem_we_o && !init_busy_o));

  p_no_write_in_fetch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_req_o |-> !mem_we_o);

  p_accept_clears_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (renew_wr_i && !key_req_o && !init_busy_o) |=> (key_req_o && !key_valid_o));

  p_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!key_valid_o || init_busy_o) |-> bus_gate_o);

  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_req_o && !key_ack_i) |=> key_req_o);

  p_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_req_o && key_ack_i) |=> (key_valid_o && !key_req_o));

  p_done_not_partial_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !init_done_o);

  p_done_after_last_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> ($past(mem_we_o) && $past(mem_addr_o) == LAST));

endmodule

bind sram_key_init_seq sram_key_init_seq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .renew_wr_i  (renew_wr_i),
  .key_req_o   (key_req_o),
  .key_ack_i   (key_ack_i),
  .key_valid_o (key_valid_o),
  .init_busy_o (init_busy_o),
  .init_done_o (init_done_o),
  .bus_gate_o  (bus_gate_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/tb_sram_key_init_seq.sv
`timescale 1ns/1ps
module tb_sram_key_init_seq;
  localparam int DEPTH = 16;
  localparam int KEY_W = 128;
  localparam int NONCE_W = 64;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic renew_wr = 0, init_wr = 0, key_ack = 0;
  logic [KEY_W-1:0] key_in = '0;
  logic [NONCE_W-1:0] nonce_in = '0;
  logic key_req, key_valid, init_busy, init_done, gate, mem_we;
  logic [KEY_W-1:0] key_out;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;

  int n_tests = 0, n_fail = 0;
  int req_count = 0, wr_cnt = 0, viol = 0;
  int ack_delay = 300, prov_cnt = 0;
  bit prov_busy = 0;
  logic [31:0] mem [DEPTH];
  int addr_hits [DEPTH];

  always #4 clk = ~clk;

  sram_key_init_seq #(.DEPTH(DEPTH), .KEY_W(KEY_W), .NONCE_W(NONCE_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .renew_wr_i(renew_wr), .init_wr_i(init_wr),
    .key_req_o(key_req), .key_ack_i(key_ack), .key_i(key_in), .nonce_i(nonce_in),
    .key_o(key_out), .key_valid_o(key_valid), .init_busy_o(init_busy),
    .init_done_o(init_done), .bus_gate_o(gate), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata));

  always @(negedge clk) begin
    key_ack = 0;
    if (key_req && !prov_busy) begin
      prov_busy = 1; prov_cnt = 0; req_count++;
    end else if (prov_busy) begin
      prov_cnt++;
      if (prov_cnt >= ack_delay) begin key_ack = 1; prov_busy = 0; end
    end
    if (key_req && mem_we) viol++;
  end

  always @(posedge clk) if (rst_n && mem_we) begin
    mem[mem_addr] <= mem_wdata;
    addr_hits[mem_addr] <= addr_hits[mem_addr] + 1;
    wr_cnt <= wr_cnt + 1;
  end

  function automatic logic [31:0] step(logic [31:0] v);
    return (v >> 1) ^ (v[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  task automatic check(string req, logic [159:0] act, logic [159:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    wr_cnt = 0;
    for (int i = 0; i < DEPTH; i++) begin addr_hits[i] = 0; mem[i] = 'x; end
  endtask

  task automatic pulse(logic r, logic i);
    @(negedge clk); renew_wr = r; init_wr = i;
    @(negedge clk); renew_wr = 0; init_wr = 0;
  endtask

  task automatic wait_valid();
    for (int k = 0; k < 2000 && !key_valid; k++) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int k = 0; k < 2000 && !init_done; k++) @(negedge clk);
  endtask

  task automatic check_fill(string req, logic [31:0] seed);
    logic [31:0] v = (seed == 0) ? 32'h9E37_79B9 : seed;
    int bad = 0, hits = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (mem[i] !== v) bad++;
      if (addr_hits[i] != 1) hits++;
      v = step(v);
    end
    check({req, " fill data"}, bad, 0);
    check({req, " single write per address"}, hits, 0);
    check({req, " write count"}, wr_cnt, DEPTH);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11 key_req", key_req, 0);
    check("R11 key_valid", key_valid, 0);
    check("R11 busy/done/we", {init_busy, init_done, mem_we}, 0);
    check("R11 gate", gate, 1);
  endtask

  task automatic t_key_fetch(logic [31:0] lo);
    ack_delay = 300;
    key_in = {4{lo ^ 32'h1357_9BDF}};
    nonce_in = {32'hFFFF_0000, lo};
    pulse(1, 0);
    check("R6 key_req raised", key_req, 1);
    check("R6 key_valid cleared", key_valid, 0);
    check("R7 gate during fetch", gate, 1);
    repeat (100) @(negedge clk);
    check("R8 request held", key_req, 1);
    wait_valid();
    check("R8 key captured", key_out, {4{lo ^ 32'h1357_9BDF}});
    check("R8 request dropped", key_req, 0);
    check("R7 gate open", gate, 0);
  endtask

  task automatic t_key_repeat();
    int rc;
    ack_delay = 60;
    rc = req_count;
    pulse(1, 0);
    repeat (10) @(negedge clk);
    pulse(1, 0);
    wait_valid();
    repeat (20) @(negedge clk);
    check("R1 repeat renew ignored (req count)", req_count - rc, 1);
    check("R1 no second request", key_req, 0);
  endtask

  task automatic t_init(logic [31:0] seed);
    clear_log();
    pulse(0, 1);
    check("R9 done cleared on init", init_done, 0);
    check("R3 busy", init_busy, 1);
    check("R7 gate during fill", gate, 1);
    wait_done();
    check("R9 done set after fill", {init_done, init_busy, mem_we}, 3'b100);
    check_fill("R4 R3", seed);
  endtask

  task automatic t_init_repeat(logic [31:0] seed);
    clear_log();
    pulse(0, 1);
    repeat (4) @(negedge clk);
    pulse(0, 1);
    wait_done();
    repeat (5) @(negedge clk);
    check_fill("R2 no restart", seed);
  endtask

  task automatic t_key_during_init(logic [31:0] seed);
    int rc = req_count;
    clear_log();
    pulse(0, 1);
    repeat (3) @(negedge clk);
    pulse(1, 0);
    check("R1 renew ignored during fill", {key_req, key_valid}, 2'b01);
    wait_done();
    repeat (5) @(negedge clk);
    check("R1 no request issued", req_count - rc, 0);
    check_fill("R1 fill intact", seed);
  endtask

  task automatic t_combined(logic [31:0] lo);
    ack_delay = 80;
    viol = 0;
    clear_log();
    key_in = {4{lo}};
    nonce_in = {32'h0, lo};
    pulse(1, 1);
    check("R5 key first", {key_req, init_busy, mem_we}, 3'b110);
    wait_done();
    check("R5 no write during fetch", viol, 0);
    check("R5 key installed", {key_valid, key_out}, {1'b1, {4{lo}}});
    check_fill("R5 new nonce", lo);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_key_fetch(32'hA5A5_0F0F);
    t_key_repeat();
    t_init(32'hA5A5_0F0F);
    t_init(32'hA5A5_0F0F);
    t_init_repeat(32'hA5A5_0F0F);
    t_key_during_init(32'hA5A5_0F0F);
    t_combined(32'h0000_BEEF);
    t_combined(32'h0);
    check("R10 zero seed fill done", init_done, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule